// File: doc/BRIEF.md
# T1 Transmit Frame Timing Generator

This block keeps the transmit-side timing of a 1.544 Mb/s DS1 stream. It steps through the 193 bit slots of each frame. Each frame has one framing slot, followed by 24 channels of 8 bits each. The block also counts frames within a multiframe. A mode input selects a 12-frame superframe or a 24-frame extended superframe. The block advances one bit slot per clock. In the framing slot it emits the framing bit. In every other slot it forwards the serial payload input with one register of delay.

The framing bit comes from a fixed pattern, a link data input or a CRC input, depending on mode and frame number. The block also decodes several timing strobes from its counters: a channel clock, a signaling-select clock, a signaling-frame flag, a link-demand clock and a multiframe marker. Upstream logic uses these strobes to line up channel data and link bits. Two sync inputs can realign the counters. A rising edge on the frame sync input starts a new frame. A rising edge on the multiframe sync input returns to the first frame of the multiframe.

Top module: `t1tx_framer`

## Requirements
- R1: While `rst_n` is low and after its release, before the first clock edge, the block is in the framing slot of frame 1. In that state `line_out`=0, `mf_out`=1, `sig_sel`=1, `sig_frame`=0, `ch_clk`=0, and `link_req` equals `esf_mode`.
- R2: A frame lasts 193 clocks: one framing slot, then 24 channels of 8 slots each. `ch_clk` is 1 during the first 4 slots of every channel and 0 during the other 4 slots and during the framing slot.
- R3: For every payload slot, `line_out` in the following cycle equals the value `pay_in` had in that slot.
- R4: With `esf_mode`=0, the framing bits of frames 1,3,5,7,9,11 are 1,0,1,0,1,0 in that order.
- R5: With `esf_mode`=0, the framing bit of an even frame is `link_in` sampled in that framing slot when `ext_s_en`=1. When `ext_s_en`=0 it follows 0,0,1,1,1,0 for frames 2,4,6,8,10,12.
- R6: With `esf_mode`=1, the framing bits of frames 4,8,12,16,20,24 are 0,0,1,0,1,1 in that order.
- R7: With `esf_mode`=1, the framing bit of frames 2,6,10,14,18,22 is `crc_in` sampled in that framing slot.
- R8: With `esf_mode`=1, the framing bit of every odd frame is `link_in` sampled in that framing slot. `ext_s_en` has no effect in this mode.
- R9: `link_req` is 1 for the whole of each frame whose framing slot carries link data, and 0 otherwise. Those are the odd frames when `esf_mode`=1 and the even frames when `esf_mode`=0, which gives a 4 kHz clock at line rate.
- R10: `mf_out` is 1 during the first half of the multiframe and 0 during the second half. The first half is frames 1–12 when `esf_mode`=1 and frames 1–6 when `esf_mode`=0.
- R11: `sig_frame` is 1 in frames 6, 12, 18 and 24. `sig_sel` is 1 in frames 1–6 and 13–18 when `esf_mode`=1. When `esf_mode`=0 it is 1 in frames 1–3 and 7–9.
- R12: A 0-to-1 change on `fsync_in` makes the next clock the framing slot of the next frame. A pulse that arrives in the last slot of a frame therefore changes nothing.
- R13: A 0-to-1 change on `mfsync_in` makes the next clock the framing slot of frame 1. This takes priority over a simultaneous `fsync_in` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1 selects the 24-frame format, 0 the 12-frame format |
| ext_s_en | input | 1 | 12-frame mode: take even-frame framing bits from `link_in` |
| fsync_in | input | 1 | Frame realignment, rising edge active |
| mfsync_in | input | 1 | Multiframe realignment, rising edge active |
| pay_in | input | 1 | Serial payload bit |
| link_in | input | 1 | Link data bit, used in link framing slots |
| crc_in | input | 1 | CRC bit, used in CRC framing slots |
| line_out | output | 1 | Serial output stream, one cycle behind its slot |
| ch_clk | output | 1 | Channel clock, high in the first half of each channel |
| sig_sel | output | 1 | Signaling-select clock |
| sig_frame | output | 1 | High during signaling frames |
| link_req | output | 1 | Link data demand clock |
| mf_out | output | 1 | Multiframe marker, 50% duty |

## Verification
The bench targets the wrap from the last slot of frame 12 or 24 back to frame 1. It also targets the shift between odd-frame and even-frame link sampling when the mode changes, and the single-slot source switch between pattern, link data and CRC bits. A design that wraps the frame counter one frame late would shift every framing pattern and strobe and would fail R4–R11. A design that sampled link data on the wrong frame parity would fail R5, R8 and R9.

Directed sync pulses hit the last slot of a frame, the middle of a frame, and both sync inputs in the same cycle. A design that reacted to an aligned pulse would drop or repeat a frame (R12). A design that let the frame sync win over the multiframe sync would not return to frame 1 (R13).

// File: rtl/t1tx_pkg.sv
package t1tx_pkg;
    // Pattern bits are stored LSB-first: bit i is the i-th occurrence.
    localparam int PAT_LEN = 6;
    localparam logic [PAT_LEN-1:0] TERM_PAT = 6'b010101;  // 1,0,1,0,1,0
    localparam logic [PAT_LEN-1:0] SIGF_PAT = 6'b011100;  // 0,0,1,1,1,0
    localparam logic [PAT_LEN-1:0] ALGN_PAT = 6'b110100;  // 0,0,1,0,1,1

    localparam int SIG_PERIOD = 6;  // frames between signaling frames

    typedef enum logic [2:0] {
        SLOT_PAY,
        SLOT_TERM,
        SLOT_SIGF,
        SLOT_ALGN,
        SLOT_CRC,
        SLOT_LINK
    } slot_e;
endpackage

// File: rtl/t1tx_counter.sv
module t1tx_counter #(
    parameter int CHANNELS   = 24,
    parameter int CH_BITS    = 8,
    parameter int ESF_FRAMES = 24,
    localparam int CH_W  = $clog2(CHANNELS),
    localparam int BIT_W = $clog2(CH_BITS),
    localparam int FRM_W = $clog2(ESF_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FRM_W-1:0] last_frm,
    input  logic             fsync_in,
    input  logic             mfsync_in,
    output logic             fbit,
    output logic [BIT_W-1:0] bitn,
    output logic [FRM_W-1:0] frm
);
    typedef struct packed {
        logic             fbit;
        logic [CH_W-1:0]  chan;
        logic [BIT_W-1:0] bitn;
        logic [FRM_W-1:0] frm;
        logic             fs_prev;
        logic             mfs_prev;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic fs_rise, mfs_rise;
    logic [FRM_W-1:0] frm_next;

    always_comb begin
        cnt_d          = cnt_q;
        cnt_d.fs_prev  = fsync_in;
        cnt_d.mfs_prev = mfsync_in;
        fs_rise  = fsync_in & ~cnt_q.fs_prev;
        mfs_rise = mfsync_in & ~cnt_q.mfs_prev;
        frm_next = (cnt_q.frm >= last_frm) ? '0 : cnt_q.frm + FRM_W'(1);

        if (mfs_rise) begin
            cnt_d.fbit = 1'b1;
            cnt_d.chan = '0;
            cnt_d.bitn = '0;
            cnt_d.frm  = '0;
        end else if (fs_rise) begin
            cnt_d.fbit = 1'b1;
            cnt_d.chan = '0;
            cnt_d.bitn = '0;
            cnt_d.frm  = frm_next;
        end else if (cnt_q.fbit) begin
            cnt_d.fbit = 1'b0;
            cnt_d.chan = '0;
            cnt_d.bitn = '0;
        end else if (cnt_q.bitn == BIT_W'(CH_BITS - 1)) begin
            cnt_d.bitn = '0;
            if (cnt_q.chan == CH_W'(CHANNELS - 1)) begin
                cnt_d.fbit = 1'b1;
                cnt_d.chan = '0;
                cnt_d.frm  = frm_next;
            end else begin
                cnt_d.chan = cnt_q.chan + CH_W'(1);
            end
        end else begin
            cnt_d.bitn = cnt_q.bitn + BIT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            cnt_q.fbit <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign fbit = cnt_q.fbit;
    assign bitn = cnt_q.bitn;
    assign frm  = cnt_q.frm;
endmodule

// File: rtl/t1tx_fbit_sel.sv
module t1tx_fbit_sel
    import t1tx_pkg::*;
#(
    parameter int FRM_W = 5
) (
    input  logic             esf_mode,
    input  logic             ext_s_en,
    input  logic             fbit,
    input  logic [FRM_W-1:0] frm,
    input  logic             link_in,
    input  logic             crc_in,
    output slot_e            slot,
    output logic             fval
);
    function automatic logic pick(input logic [PAT_LEN-1:0] pat, input int idx);
        return (idx < PAT_LEN) ? pat[idx] : 1'b0;
    endfunction

    int half_idx, quad_idx;

    always_comb begin
        half_idx = int'(frm >> 1);
        quad_idx = int'(frm >> 2);
        slot     = SLOT_PAY;
        fval     = 1'b0;
        if (fbit) begin
            if (esf_mode) begin
                if (!frm[0]) begin
                    slot = SLOT_LINK;
                    fval = link_in;
                end else if (!frm[1]) begin
                    slot = SLOT_CRC;
                    fval = crc_in;
                end else begin
                    slot = SLOT_ALGN;
                    fval = pick(ALGN_PAT, quad_idx);
                end
            end else if (!frm[0]) begin
                slot = SLOT_TERM;
                fval = pick(TERM_PAT, half_idx);
            end else if (ext_s_en) begin
                slot = SLOT_LINK;
                fval = link_in;
            end else begin
                slot = SLOT_SIGF;
                fval = pick(SIGF_PAT, half_idx);
            end
        end
    end
endmodule

// File: rtl/t1tx_strobes.sv
module t1tx_strobes
    import t1tx_pkg::*;
#(
    parameter int CH_BITS    = 8,
    parameter int SF_FRAMES  = 12,
    parameter int ESF_FRAMES = 24,
    localparam int BIT_W = $clog2(CH_BITS),
    localparam int FRM_W = $clog2(ESF_FRAMES)
) (
    input  logic             esf_mode,
    input  logic             fbit,
    input  logic [BIT_W-1:0] bitn,
    input  logic [FRM_W-1:0] frm,
    output logic             ch_clk,
    output logic             sig_sel,
    output logic             sig_frame,
    output logic             link_req,
    output logic             mf_out
);
    localparam logic [FRM_W-1:0] SIG_P    = FRM_W'(SIG_PERIOD);
    localparam logic [FRM_W-1:0] SIG_HALF = FRM_W'(SIG_PERIOD / 2);

    logic [FRM_W-1:0] grp_long, grp_short, frm_mod;

    always_comb begin
        grp_long  = frm / SIG_P;
        grp_short = frm / SIG_HALF;
        frm_mod   = frm % SIG_P;
        ch_clk    = !fbit && (bitn < BIT_W'(CH_BITS / 2));
        sig_frame = (frm_mod == SIG_P - FRM_W'(1));
        sig_sel   = esf_mode ? !grp_long[0] : !grp_short[0];
        link_req  = esf_mode ? !frm[0] : frm[0];
        mf_out    = frm < (esf_mode ? FRM_W'(ESF_FRAMES / 2) : FRM_W'(SF_FRAMES / 2));
    end
endmodule

// File: rtl/t1tx_framer.sv
module t1tx_framer
    import t1tx_pkg::*;
#(
    parameter int CHANNELS   = 24,
    parameter int CH_BITS    = 8,
    parameter int SF_FRAMES  = 12,
    parameter int ESF_FRAMES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic esf_mode,
    input  logic ext_s_en,
    input  logic fsync_in,
    input  logic mfsync_in,
    input  logic pay_in,
    input  logic link_in,
    input  logic crc_in,
    output logic line_out,
    output logic ch_clk,
    output logic sig_sel,
    output logic sig_frame,
    output logic link_req,
    output logic mf_out
);
    localparam int BIT_W = $clog2(CH_BITS);
    localparam int FRM_W = $clog2(ESF_FRAMES);

    typedef struct packed {
        logic line;
    } out_t;

    logic             fbit_w;
    logic [BIT_W-1:0] bitn_w;
    logic [FRM_W-1:0] frm_w;
    logic [FRM_W-1:0] last_frm;
    slot_e            slot_w;
    logic             fval_w;
    out_t             out_d, out_q;

    assign last_frm = esf_mode ? FRM_W'(ESF_FRAMES - 1) : FRM_W'(SF_FRAMES - 1);

    t1tx_counter #(
        .CHANNELS  (CHANNELS),
        .CH_BITS   (CH_BITS),
        .ESF_FRAMES(ESF_FRAMES)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_frm (last_frm),
        .fsync_in (fsync_in),
        .mfsync_in(mfsync_in),
        .fbit     (fbit_w),
        .bitn     (bitn_w),
        .frm      (frm_w)
    );

    t1tx_fbit_sel #(
        .FRM_W(FRM_W)
    ) u_fsel (
        .esf_mode(esf_mode),
        .ext_s_en(ext_s_en),
        .fbit    (fbit_w),
        .frm     (frm_w),
        .link_in (link_in),
        .crc_in  (crc_in),
        .slot    (slot_w),
        .fval    (fval_w)
    );

    t1tx_strobes #(
        .CH_BITS   (CH_BITS),
        .SF_FRAMES (SF_FRAMES),
        .ESF_FRAMES(ESF_FRAMES)
    ) u_strb (
        .esf_mode (esf_mode),
        .fbit     (fbit_w),
        .bitn     (bitn_w),
        .frm      (frm_w),
        .ch_clk   (ch_clk),
        .sig_sel  (sig_sel),
        .sig_frame(sig_frame),
        .link_req (link_req),
        .mf_out   (mf_out)
    );

    always_comb begin
        out_d      = out_q;
        out_d.line = (slot_w == SLOT_PAY) ? pay_in : fval_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign line_out = out_q.line;
endmodule

// File: rtl/t1tx_framer_chk.sv
module t1tx_framer_chk #(
    parameter int FRM_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             esf_mode,
    input logic             fsync_in,
    input logic             mfsync_in,
    input logic             pay_in,
    input logic             crc_in,
    input logic             line_out,
    input logic             ch_clk,
    input logic             sig_sel,
    input logic             sig_frame,
    input logic             link_req,
    input logic             mf_out,
    input logic             fbit,
    input logic [FRM_W-1:0] frm
);
    // R3
    pay_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fbit |=> line_out == $past(pay_in));

    // R7
    crc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit && esf_mode && frm[1:0] == 2'd1) |=> line_out == $past(crc_in));

    // R13
    mf_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mfsync_in && !$past(mfsync_in)) |=> (mf_out && sig_sel && !ch_clk && !sig_frame));

    // R12
    fs_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_in && !$past(fsync_in)) |=> (fbit && !ch_clk));

    // R9
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fbit && $stable(esf_mode)) |-> $stable(link_req));

    // R11
    sig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_frame) |-> fbit);

    // R10
    mf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mf_out) && $stable(esf_mode)) |-> (fbit && frm == '0));
endmodule

bind t1tx_framer t1tx_framer_chk #(.FRM_W(FRM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .esf_mode (esf_mode),
    .fsync_in (fsync_in),
    .mfsync_in(mfsync_in),
    .pay_in   (pay_in),
    .crc_in   (crc_in),
    .line_out (line_out),
    .ch_clk   (ch_clk),
    .sig_sel  (sig_sel),
    .sig_frame(sig_frame),
    .link_req (link_req),
    .mf_out   (mf_out),
    .fbit     (fbit_w),
    .frm      (frm_w)
);

// File: tb/tb_t1tx_framer.sv
`timescale 1ns/1ps
module tb_t1tx_framer;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, esf_mode, ext_s_en, fsync_in, mfsync_in, pay_in, link_in, crc_in;
    logic line_out, ch_clk, sig_sel, sig_frame, link_req, mf_out;

    t1tx_framer dut (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .ext_s_en(ext_s_en),
        .fsync_in(fsync_in), .mfsync_in(mfsync_in), .pay_in(pay_in),
        .link_in(link_in), .crc_in(crc_in), .line_out(line_out),
        .ch_clk(ch_clk), .sig_sel(sig_sel), .sig_frame(sig_frame),
        .link_req(link_req), .mf_out(mf_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // independent model of the slot position
    int m_fb, m_ch, m_bi, m_fr;
    bit m_fsp, m_mfsp;

    int TERM[6] = '{1, 0, 1, 0, 1, 0};
    int SIGF[6] = '{0, 0, 1, 1, 1, 0};
    int ALGN[6] = '{0, 0, 1, 0, 1, 1};

    function automatic int nframes(logic e);
        return e ? 24 : 12;
    endfunction

    task automatic chk(logic act, logic exp, string req, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b (frame %0d ch %0d bit %0d fslot %0d)",
                     req, what, act, exp, m_fr + 1, m_ch, m_bi, m_fb);
        end
    endtask

    function automatic logic exp_frame_bit(logic e, logic s, int fr, logic lk, logic cr,
                                           output string tag);
        int f = fr + 1;
        if (!e) begin
            if (f % 2 == 1) begin tag = "R4"; return TERM[(f - 1) / 2] != 0; end
            if (s) begin tag = "R5"; return lk; end
            tag = "R5";
            return SIGF[f / 2 - 1] != 0;
        end
        if (f % 2 == 1) begin tag = "R8"; return lk; end
        if (f % 4 == 2) begin tag = "R7"; return cr; end
        tag = "R6";
        return ALGN[f / 4 - 1] != 0;
    endfunction

    task automatic check_strobes();
        chk(ch_clk, (m_fb == 0) && (m_bi < 4), "R2", "ch_clk");
        chk(mf_out, m_fr < nframes(esf_mode) / 2, "R10", "mf_out");
        chk(sig_frame, (m_fr % 6) == 5, "R11", "sig_frame");
        chk(sig_sel, esf_mode ? ((m_fr / 6) % 2 == 0) : ((m_fr / 3) % 2 == 0), "R11", "sig_sel");
        chk(link_req, esf_mode ? (m_fr % 2 == 0) : (m_fr % 2 == 1), "R9", "link_req");
    endtask

    // called at a falling edge; returns at the next falling edge with checks done
    task automatic step(logic p, logic l, logic c, logic fs, logic mfs);
        logic  exp_line;
        string tag;
        bit    fsr, mfsr;
        int    nf;
        pay_in = p; link_in = l; crc_in = c; fsync_in = fs; mfsync_in = mfs;
        if (m_fb != 0) exp_line = exp_frame_bit(esf_mode, ext_s_en, m_fr, l, c, tag);
        else begin exp_line = p; tag = "R3"; end
        fsr  = fs && !m_fsp;
        mfsr = mfs && !m_mfsp;
        m_fsp = fs; m_mfsp = mfs;
        nf = (m_fr >= nframes(esf_mode) - 1) ? 0 : m_fr + 1;
        if (mfsr) begin
            m_fb = 1; m_ch = 0; m_bi = 0; m_fr = 0;
        end else if (fsr) begin
            m_fb = 1; m_ch = 0; m_bi = 0; m_fr = nf;
        end else if (m_fb != 0) begin
            m_fb = 0; m_ch = 0; m_bi = 0;
        end else if (m_bi == 7) begin
            m_bi = 0;
            if (m_ch == 23) begin m_fb = 1; m_ch = 0; m_fr = nf; end
            else m_ch++;
        end else m_bi++;
        @(posedge clk);
        @(negedge clk);
        chk(line_out, exp_line, tag, "line_out");
        check_strobes();
        if (mfsr) chk(mf_out, 1'b1, "R13", "mf_out after multiframe sync");
        else if (fsr) chk(ch_clk, 1'b0, "R12", "ch_clk after frame sync");
    endtask

    task automatic rstep(int n, int sync_odds);
        for (int i = 0; i < n; i++) begin
            logic fs = (sync_odds > 0) && ($urandom_range(sync_odds - 1) == 0);
            step(1'($urandom), 1'($urandom), 1'($urandom), fs, 1'b0);
        end
    endtask

    task automatic goto_last_slot();
        for (int i = 0; i < 200; i++) begin
            if (m_fb == 0 && m_ch == 23 && m_bi == 7) break;
            rstep(1, 0);
        end
    endtask

    initial begin
        int fr_before;
        void'($urandom(32'd1931));
        rst_n = 0; esf_mode = 1; ext_s_en = 0; fsync_in = 0; mfsync_in = 0;
        pay_in = 0; link_in = 0; crc_in = 0;
        m_fb = 1; m_ch = 0; m_bi = 0; m_fr = 0; m_fsp = 0; m_mfsp = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state, before the first active edge
        chk(line_out, 1'b0, "R1", "line_out at reset");
        chk(mf_out, 1'b1, "R1", "mf_out at reset");
        chk(sig_sel, 1'b1, "R1", "sig_sel at reset");
        chk(sig_frame, 1'b0, "R1", "sig_frame at reset");
        chk(ch_clk, 1'b0, "R1", "ch_clk at reset");
        chk(link_req, 1'b1, "R1", "link_req at reset");

        // extended mode, ext_s_en set has no effect (R8)
        ext_s_en = 1;
        rstep(2 * 24 * 193 + 7, 0);

        // R12: aligned frame sync changes nothing
        goto_last_slot();
        fr_before = m_fr;
        step(1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 1'b0);
        chk(1'(m_fr == ((fr_before + 1) % 24)), 1'b1, "R12", "aligned pulse frame index");
        rstep(400, 0);

        // R12: misaligned frame sync mid-frame
        rstep(57, 0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        rstep(500, 0);

        // R13: both syncs rise together, multiframe wins
        rstep(91, 0);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(1'(m_fr == 0), 1'b1, "R13", "model frame after joint sync");

        // standard mode, pattern S bits (R4, R5)
        esf_mode = 0; ext_s_en = 0;
        rstep(2 * 12 * 193 + 3, 0);

        // standard mode, external S bits (R5)
        rstep(33, 0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        ext_s_en = 1;
        rstep(2 * 12 * 193, 0);

        // aligned multiframe sync at end of last frame (R13)
        for (int i = 0; i < 12 * 193 + 2; i++) begin
            if (m_fb == 0 && m_ch == 23 && m_bi == 7 && m_fr == 11) break;
            rstep(1, 0);
        end
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

        // random frame sync pulses in both modes
        rstep(5000, 700);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        esf_mode = 1; ext_s_en = 0;
        rstep(6000, 900);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule